// File: doc/BRIEF.md
# LCD-Shared Output Port Controller

This block controls an eight-pin output port in which every pin is shared between an LCD frontplane (segment) driver and a general-purpose data latch. A per-pin mux register assigns each pin to one of the two. After reset the LCD owns all pins, and the general-purpose path stays disconnected until software sets mux bits. Each pin's pad control is a drive value plus separate N-channel and P-channel enables. A per-pin select tells the pad which source to pass: the LCD segment source or the port's own drive.

A simple CPU bus reaches the block. The data latch and the mux register share one address, and a bank-select input chooses between them. While bank select is low, that address is the data latch. While bank select is high, it is the mux register. Two lock inputs, one per nibble, freeze the matching half of the mux register against writes. A separate open-drain register holds one bit per nibble. When such a bit is set, the P-channel drivers of its four pins are off, but only on pins that are in general-purpose mode.

Top module: `segport_ctrl`

## Requirements
- R1: A reset sets the data latch to 0xFF, the mux register to 0x00 and the open-drain register to 0. It also sets `lcd_sel` to 0xFF and sets `pad_out`, `pad_nen` and `pad_pen` to 0x00.
- R2: A read of `ADDR_PORT` with `bank_sel`=0 returns the data latch contents, whatever the pin ownership.
- R3: A write to `ADDR_PORT` with `bank_sel`=0 always updates the data latch. It does not change the outputs of any pin whose mux bit is 0.
- R4: With `bank_sel`=1, reads and writes of `ADDR_PORT` reach the mux register, and the data latch is left unchanged.
- R5: Mux bit i = 0 gives pin i to the LCD: `lcd_sel[i]`=1, and `pad_out[i]`, `pad_nen[i]` and `pad_pen[i]` are 0. Mux bit i = 1 gives pin i to the port: `lcd_sel[i]`=0.
- R6: While `lock_hi`=1, a mux write leaves mux bits 7..4 unchanged. While `lock_lo`=1, a mux write leaves bits 3..0 unchanged. The two locks act independently, and unlocked bits take the written value.
- R7: A general-purpose pin in push-pull mode has `pad_out`=latch, `pad_pen`=latch and `pad_nen`=~latch.
- R8: Bit 1 of the open-drain register covers pins 7..4 and bit 0 covers pins 3..0. On a covered general-purpose pin, `pad_pen`=0 and `pad_nen`=~latch.
- R9: The open-drain bits have no effect on pins that the LCD owns.
- R10: The outputs change on the second rising edge after a write strobe is sampled, and `rdata` is valid after the first rising edge following a read strobe.
- R11: A read of `ADDR_ODC` returns the two open-drain bits in bits 1..0 and zeros above them. Writes to `ADDR_ODC` take only `wdata[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | 1 maps the mux register onto `ADDR_PORT` |
| lock_hi | input | 1 | Blocks writes to mux bits 7..4 |
| lock_lo | input | 1 | Blocks writes to mux bits 3..0 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_out | output | 8 | Per-pin general-purpose drive value |
| pad_nen | output | 8 | Per-pin N-channel enable |
| pad_pen | output | 8 | Per-pin P-channel enable |
| lcd_sel | output | 8 | 1 passes the LCD segment source to the pin |

## Verification
A register write is sampled on the first rising edge, and the pad outputs follow one rising edge later. The bench drives on falling edges and checks the pads on the falling edge after that second rising edge. Once it also looks at the falling edge between the two edges, to confirm that the old value is still held. A read result is due one rising edge after the strobe and is sampled on the following falling edge. Every expectation comes from a model held in the bench of the three registers and the pin rules.

// File: rtl/segport_pkg.sv
package segport_pkg;

  // Drive state of one pad
  typedef struct packed {
    logic drv;
    logic nen;
    logic pen;
    logic lcd;
  } pin_drv_t;

  // Decode ownership, latch value and open-drain into pad controls
  function automatic pin_drv_t pin_decode(input logic gp, input logic latch, input logic od);
    pin_drv_t r;
    r.lcd = ~gp;
    r.drv = gp & latch;
    r.nen = gp & ~latch;
    r.pen = gp & latch & ~od;
    return r;
  endfunction

endpackage

// File: rtl/segport_regs.sv
module segport_regs #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_PORT = 8'h04,
  parameter logic [AW-1:0] ADDR_ODC  = 8'h0C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          bank_sel,
  input  logic          lock_hi,
  input  logic          lock_lo,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] mux_q,
  output logic [1:0]    od_q,
  output logic [DW-1:0] rdata
);
  localparam int NIB = DW / 2;

  logic          hit_port;
  logic          hit_odc;
  logic [DW-1:0] mux_mask;
  logic [DW-1:0] rd_next;

  assign hit_port = (addr == ADDR_PORT);
  assign hit_odc  = (addr == ADDR_ODC);
  assign mux_mask = {{NIB{~lock_hi}}, {NIB{~lock_lo}}};

  // data latch
  always_ff @(posedge clk) begin
    if (rst)
      data_q <= '1;
    else if (wr_en && hit_port && !bank_sel)
      data_q <= wdata;
  end

  // banked mux register with nibble locks
  always_ff @(posedge clk) begin
    if (rst)
      mux_q <= '0;
    else if (wr_en && hit_port && bank_sel)
      mux_q <= (mux_q & ~mux_mask) | (wdata & mux_mask);
  end

  // open-drain nibble controls
  always_ff @(posedge clk) begin
    if (rst)
      od_q <= '0;
    else if (wr_en && hit_odc)
      od_q <= wdata[1:0];
  end

  always_comb begin
    rd_next = '0;
    if (hit_port)
      rd_next = bank_sel ? mux_q : data_q;
    else if (hit_odc)
      rd_next[1:0] = od_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_next;
  end

endmodule

// File: rtl/segport_pin.sv
module segport_pin
  import segport_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic gp,
  input  logic latch,
  input  logic od,
  output logic pad_out,
  output logic pad_nen,
  output logic pad_pen,
  output logic lcd_sel
);
  pin_drv_t nxt;

  always_comb nxt = pin_decode(gp, latch, od);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_nen <= 1'b0;
      pad_pen <= 1'b0;
      lcd_sel <= 1'b1;
    end else begin
      pad_out <= nxt.drv;
      pad_nen <= nxt.nen;
      pad_pen <= nxt.pen;
      lcd_sel <= nxt.lcd;
    end
  end

endmodule

// File: rtl/segport_ctrl.sv
module segport_ctrl #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_PORT = 8'h04,
  parameter logic [AW-1:0] ADDR_ODC  = 8'h0C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bank_sel,
  input  logic          lock_hi,
  input  logic          lock_lo,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_nen,
  output logic [DW-1:0] pad_pen,
  output logic [DW-1:0] lcd_sel
);
  localparam int NIB = DW / 2;

  logic [DW-1:0] data_q;
  logic [DW-1:0] mux_q;
  logic [1:0]    od_q;

  segport_regs #(
    .DW(DW), .AW(AW), .ADDR_PORT(ADDR_PORT), .ADDR_ODC(ADDR_ODC)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .bank_sel(bank_sel), .lock_hi(lock_hi), .lock_lo(lock_lo),
    .data_q(data_q), .mux_q(mux_q), .od_q(od_q), .rdata(rdata)
  );

  for (genvar i = 0; i < DW; i++) begin : g_pin
    localparam int OD_IDX = (i >= NIB) ? 1 : 0;
    segport_pin u_pin (
      .clk(clk), .rst(rst), .gp(mux_q[i]), .latch(data_q[i]), .od(od_q[OD_IDX]),
      .pad_out(pad_out[i]), .pad_nen(pad_nen[i]), .pad_pen(pad_pen[i]),
      .lcd_sel(lcd_sel[i])
    );
  end

endmodule

// File: rtl/segport_ctrl_chk.sv
module segport_ctrl_chk #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_PORT = 8'h04
) (
  input logic          clk,
  input logic          rst,
  input logic          bank_sel,
  input logic          lock_hi,
  input logic          lock_lo,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] pad_nen,
  input logic [DW-1:0] pad_pen,
  input logic [DW-1:0] lcd_sel,
  input logic [DW-1:0] data_q,
  input logic [DW-1:0] mux_q,
  input logic [1:0]    od_q
);
  localparam int NIB = DW / 2;

  // R7
  no_both_drivers_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_nen & pad_pen) == '0);

  // R9
  lcd_pins_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (lcd_sel & (pad_nen | pad_pen)) == '0);

  // R6
  lock_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank_sel && addr == ADDR_PORT && lock_hi) |=> mux_q[DW-1:NIB] == $past(mux_q[DW-1:NIB]));

  // R6
  lock_lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank_sel && addr == ADDR_PORT && lock_lo) |=> mux_q[NIB-1:0] == $past(mux_q[NIB-1:0]));

  // R4
  bank_keeps_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank_sel) |=> data_q == $past(data_q));

  // R8
  od_hi_pen_off_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pen[DW-1:NIB] != '0) |-> !$past(od_q[1]));

  // R10
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !bank_sel && addr == ADDR_PORT) |=> rdata == $past(data_q));

endmodule

bind segport_ctrl segport_ctrl_chk #(.DW(DW), .AW(AW), .ADDR_PORT(ADDR_PORT)) u_chk (
  .clk(clk), .rst(rst), .bank_sel(bank_sel), .lock_hi(lock_hi), .lock_lo(lock_lo),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .pad_nen(pad_nen), .pad_pen(pad_pen), .lcd_sel(lcd_sel),
  .data_q(data_q), .mux_q(mux_q), .od_q(od_q)
);

// File: tb/segport_ctrl_test.sv
module segport_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_PORT = 8'h04;
  localparam logic [7:0] A_ODC  = 8'h0C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bank_sel = 1'b0, lock_hi = 1'b0, lock_lo = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, pad_out, pad_nen, pad_pen, lcd_sel;

  int checks = 0;
  int fails = 0;

  logic [7:0] m_latch, m_mux;
  logic [1:0] m_od;

  always #(CLK_PERIOD/2) clk = ~clk;

  segport_ctrl uut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .lock_hi(lock_hi), .lock_lo(lock_lo),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pad_out(pad_out), .pad_nen(pad_nen), .pad_pen(pad_pen), .lcd_sel(lcd_sel)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic bank);
    @(negedge clk);
    addr = a; wdata = d; bank_sel = bank; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic bank, output logic [7:0] d);
    @(negedge clk);
    addr = a; bank_sel = bank; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // model of pin outputs built from the requirements
  task automatic chk_pins(input string req);
    logic [7:0] e_out, e_n, e_p, e_l;
    for (int i = 0; i < 8; i++) begin
      logic od;
      od = (i >= 4) ? m_od[1] : m_od[0];
      e_l[i]   = ~m_mux[i];
      e_out[i] = m_mux[i] & m_latch[i];
      e_n[i]   = m_mux[i] & ~m_latch[i];
      e_p[i]   = m_mux[i] & m_latch[i] & ~od;
    end
    chk(req, "lcd_sel", lcd_sel, e_l);
    chk(req, "pad_out", pad_out, e_out);
    chk(req, "pad_nen", pad_nen, e_n);
    chk(req, "pad_pen", pad_pen, e_p);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    m_latch = 8'hFF; m_mux = 8'h00; m_od = 2'b00;
    chk_pins("R1");
    bus_read(A_PORT, 1'b0, d); chk("R1", "latch", d, 8'hFF);
    bus_read(A_PORT, 1'b1, d); chk("R1", "mux", d, 8'h00);
    bus_read(A_ODC, 1'b0, d);  chk("R1", "odc", d, 8'h00);
  endtask

  task automatic t_data_lcd_owned();
    logic [7:0] d;
    bus_write(A_PORT, 8'h5A, 1'b0); m_latch = 8'h5A;
    settle();
    chk_pins("R3");
    bus_read(A_PORT, 1'b0, d); chk("R2", "latch read while LCD owns", d, 8'h5A);
  endtask

  task automatic t_mux_bank();
    logic [7:0] d;
    bus_write(A_PORT, 8'hFF, 1'b1); m_mux = 8'hFF;
    chk("R10", "lcd_sel one edge after write", lcd_sel, 8'hFF);
    settle();
    chk("R10", "lcd_sel two edges after write", lcd_sel, 8'h00);
    chk_pins("R7");
    chk_pins("R5");
    bus_read(A_PORT, 1'b1, d); chk("R4", "mux read", d, 8'hFF);
    bus_read(A_PORT, 1'b0, d); chk("R4", "latch kept", d, 8'h5A);
    bus_write(A_PORT, 8'h3C, 1'b0); m_latch = 8'h3C;
    settle();
    chk_pins("R7");
  endtask

  task automatic t_open_drain();
    logic [7:0] d;
    bus_write(A_ODC, 8'hFE, 1'b0); m_od = 2'b10;
    settle();
    chk_pins("R8");
    bus_read(A_ODC, 1'b0, d); chk("R11", "odc read", d, 8'h02);
    bus_write(A_ODC, 8'h01, 1'b0); m_od = 2'b01;
    settle();
    chk_pins("R8");
  endtask

  task automatic t_locks();
    logic [7:0] d;
    lock_hi = 1'b1;
    bus_write(A_PORT, 8'h00, 1'b1); m_mux = 8'hF0;
    bus_read(A_PORT, 1'b1, d); chk("R6", "hi lock", d, 8'hF0);
    lock_hi = 1'b0; lock_lo = 1'b1;
    bus_write(A_PORT, 8'hAA, 1'b1); m_mux = 8'hA0;
    bus_read(A_PORT, 1'b1, d); chk("R6", "lo lock", d, 8'hA0);
    lock_lo = 1'b0;
    settle();
    chk_pins("R5");
  endtask

  task automatic t_od_on_lcd();
    bus_write(A_ODC, 8'h03, 1'b0); m_od = 2'b11;
    bus_write(A_PORT, 8'h00, 1'b0); m_latch = 8'h00;
    settle();
    chk_pins("R9");
    bus_write(A_ODC, 8'h00, 1'b0); m_od = 2'b00;
    settle();
    chk_pins("R9");
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_data_lcd_owned();
    t_mux_bank();
    t_open_drain();
    t_locks();
    t_od_on_lcd();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule